// File: doc/BRIEF.md
# Pipeline Forwarding and Stall Unit

This block is the hazard controller of a five-stage in-order integer pipeline with fetch, decode, execute, memory and writeback stages. Each cycle it looks at the register numbers and the write, load and memory-access flags held in the decode, execute, memory and writeback pipeline registers. From these it drives the operand multiplexer selects for the execute stage and for the branch comparator that sits in decode. It also drives the controls that freeze the front of the pipe or inject no-ops into it. The unit is purely combinational: the pipeline registers it watches live outside it, and its outputs act on those registers at the next clock edge.

A forwarding-enable input switches between two policies. With forwarding on, results still waiting in the execute/memory and memory/writeback registers feed consumers directly, and the unit stalls only when no register yet holds the value. With forwarding off, a consumer waits in decode until its producer reaches writeback, and then reads the register file in that same cycle. A second input declares that instructions and data share one memory port. In that case a load or store that is in the memory stage takes the port away from fetch for that cycle.

Top module: `fwd_stall_unit`

## Requirements
- R1: Each execute-stage operand select takes the value 1 (execute/memory register) when that operand matches a writing destination in the memory stage. Otherwise it takes 2 (memory/writeback register) when the operand matches a writing destination in the writeback stage. Otherwise it takes 0 (register file). The memory stage wins when both match.
- R2: Register number 0 never produces a forwarding select other than 0 and never causes a stall, whatever the write and load flags say.
- R3: With forwarding on, a non-branch decode instruction whose used source matches the destination of a load in the execute stage causes a data stall. The same match with a non-load producer does not.
- R4: With forwarding on, a branch in decode stalls when a used source matches any writing destination in execute, or a load destination in memory. When the match is with a non-load in memory, its comparator select is 1. When the match is only with writeback, its comparator select is 2. A memory-stage load match shadows an older writeback match and gives select 0.
- R5: With forwarding off, all four selects are 0. A used decode source that matches a writing destination in execute or memory causes a data stall, and a match only in writeback does not.
- R6: A decode source whose use flag is low never causes a stall and always gives a comparator select of 0. Comparator selects are also 0 when decode holds no branch.
- R7: A data stall raises the PC hold, the IF/ID hold and the ID/EX bubble together, and keeps the IF/ID bubble low.
- R8: A structural conflict occurs when the shared-port flag is high and the memory stage accesses memory. It raises the PC hold. Without a data stall it also loads a bubble into IF/ID while decode advances. When a data stall occurs in the same cycle, the IF/ID hold takes the place of the IF/ID bubble.
- R9: With no matches and no structural conflict, all control outputs are low and all selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_en | input | 1 | 1 selects the forwarding policy, 0 the wait-for-writeback policy |
| single_port | input | 1 | Instruction fetch and data access share one memory port |
| id_rs1 | input | REG_AW | First source register of the decode instruction |
| id_rs2 | input | REG_AW | Second source register of the decode instruction |
| id_use1 | input | 1 | Decode instruction reads its first source |
| id_use2 | input | 1 | Decode instruction reads its second source |
| id_branch | input | 1 | Decode instruction is a branch compared in decode |
| ex_rs1 | input | REG_AW | First source register of the execute instruction |
| ex_rs2 | input | REG_AW | Second source register of the execute instruction |
| ex_rd | input | REG_AW | Destination of the execute instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_access | input | 1 | Memory-stage instruction is a load or a store |
| wb_rd | input | REG_AW | Destination of the writeback instruction |
| wb_wr | input | 1 | Writeback instruction writes a register |
| ex_sel_a | output | 2 | Execute operand A source: 0 regfile, 1 EX/MEM, 2 MEM/WB |
| ex_sel_b | output | 2 | Execute operand B source, same encoding |
| br_sel_a | output | 2 | Branch comparator operand A source, same encoding |
| br_sel_b | output | 2 | Branch comparator operand B source, same encoding |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the IF/ID register |
| ifid_bubble | output | 1 | Load a no-op into IF/ID |
| idex_bubble | output | 1 | Load a no-op into ID/EX |

## Verification
A data stall and a structural conflict can fall in the same cycle, because a load sitting in the memory stage takes the shared port while an instruction in decode still waits for an operand. The bench provokes this with a load in memory under the shared-port flag, combined first with a load-use match on an execute-stage load and then with a branch that depends on the memory-stage load itself. The outcome is judged by the freeze taking over: PC and IF/ID hold, ID/EX gets the bubble, and IF/ID must not receive one. A seeded random sweep with small register numbers then compares every output against an independent model, so that such overlaps also occur alongside matches on register 0 and in both policies.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Widest register number the helpers accept; callers zero-extend.
  localparam int HZ_AW_MAX = 16;

  // Operand source encoding shared by the execute and branch muxes.
  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } src_sel_e;

  // A source depends on a producer when the producer writes the same,
  // non-zero register.
  function automatic logic dest_hit(input logic [HZ_AW_MAX-1:0] src,
                                    input logic [HZ_AW_MAX-1:0] rd,
                                    input logic                 wr);
    return wr && (rd != '0) && (src == rd);
  endfunction

endpackage

// File: rtl/hz_ex_fwd.sv
module hz_ex_fwd
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              fwd_en,
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wr,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wr,
  output src_sel_e          sel
);

  logic hit_mem;
  logic hit_wb;

  assign hit_mem = dest_hit(HZ_AW_MAX'(src), HZ_AW_MAX'(mem_rd), mem_wr);
  assign hit_wb  = dest_hit(HZ_AW_MAX'(src), HZ_AW_MAX'(wb_rd), wb_wr);

  // Younger producer first; the register file is the fallback.
  always_comb begin
    sel = SRC_RF;
    if (fwd_en) begin
      if (hit_mem)     sel = SRC_EXMEM;
      else if (hit_wb) sel = SRC_MEMWB;
    end
  end

endmodule

// File: rtl/hz_id_ctrl.sv
module hz_id_ctrl
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              fwd_en,
  input  logic              is_branch,
  input  logic              use_src,
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wr,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wr,
  input  logic              mem_load,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wr,
  output src_sel_e          br_sel,
  output logic              need_stall
);

  logic hit_ex;
  logic hit_mem;
  logic hit_wb;

  assign hit_ex  = use_src && dest_hit(HZ_AW_MAX'(src), HZ_AW_MAX'(ex_rd),  ex_wr);
  assign hit_mem = use_src && dest_hit(HZ_AW_MAX'(src), HZ_AW_MAX'(mem_rd), mem_wr);
  assign hit_wb  = use_src && dest_hit(HZ_AW_MAX'(src), HZ_AW_MAX'(wb_rd),  wb_wr);

  always_comb begin
    br_sel     = SRC_RF;
    need_stall = 1'b0;
    if (!fwd_en) begin
      // Wait until the producer sits in writeback; the register file
      // then hands over the value written in that cycle.
      need_stall = hit_ex || hit_mem;
    end else if (is_branch) begin
      // The comparator runs in decode: nothing in execute is ready yet,
      // and a load in memory only has its data at the end of the stage.
      need_stall = hit_ex || (hit_mem && mem_load);
      if (hit_mem) begin
        if (!mem_load) br_sel = SRC_EXMEM;
      end else if (hit_wb) begin
        br_sel = SRC_MEMWB;
      end
    end else begin
      // Execute-stage forwarding covers everything except load-use.
      need_stall = hit_ex && ex_load;
    end
  end

endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl #(
  parameter int N_SRC = 2
) (
  input  logic [N_SRC-1:0] need_stall,
  input  logic             single_port,
  input  logic             mem_access,
  output logic             data_stall,
  output logic             struct_conflict,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             ifid_bubble,
  output logic             idex_bubble
);

  assign data_stall      = |need_stall;
  assign struct_conflict = single_port && mem_access;

  // A data stall freezes PC and IF/ID and empties ID/EX. A lost fetch
  // only keeps the PC and voids IF/ID, unless decode is frozen anyway.
  assign pc_hold     = data_stall || struct_conflict;
  assign ifid_hold   = data_stall;
  assign idex_bubble = data_stall;
  assign ifid_bubble = struct_conflict && !data_stall;

endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              fwd_en,
  input  logic              single_port,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_use1,
  input  logic              id_use2,
  input  logic              id_branch,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wr,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wr,
  input  logic              mem_load,
  input  logic              mem_access,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wr,
  output logic [1:0]        ex_sel_a,
  output logic [1:0]        ex_sel_b,
  output logic [1:0]        br_sel_a,
  output logic [1:0]        br_sel_b,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              ifid_bubble,
  output logic              idex_bubble
);

  localparam int N_SRC = 2;

  logic [REG_AW-1:0] id_src    [N_SRC];
  logic [REG_AW-1:0] ex_src    [N_SRC];
  logic [N_SRC-1:0]  id_use;
  src_sel_e          ex_sel    [N_SRC];
  src_sel_e          br_sel    [N_SRC];
  logic [N_SRC-1:0]  need_stall;
  logic              data_stall;
  logic              struct_conflict;

  assign id_src[0] = id_rs1;
  assign id_src[1] = id_rs2;
  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;
  assign id_use    = {id_use2, id_use1};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    hz_ex_fwd #(.REG_AW(REG_AW)) u_ex_fwd (
      .fwd_en (fwd_en),
      .src    (ex_src[g]),
      .mem_rd (mem_rd),
      .mem_wr (mem_wr),
      .wb_rd  (wb_rd),
      .wb_wr  (wb_wr),
      .sel    (ex_sel[g])
    );

    hz_id_ctrl #(.REG_AW(REG_AW)) u_id_ctrl (
      .fwd_en     (fwd_en),
      .is_branch  (id_branch),
      .use_src    (id_use[g]),
      .src        (id_src[g]),
      .ex_rd      (ex_rd),
      .ex_wr      (ex_wr),
      .ex_load    (ex_load),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .mem_load   (mem_load),
      .wb_rd      (wb_rd),
      .wb_wr      (wb_wr),
      .br_sel     (br_sel[g]),
      .need_stall (need_stall[g])
    );
  end

  hz_stall_ctrl #(.N_SRC(N_SRC)) u_stall (
    .need_stall      (need_stall),
    .single_port     (single_port),
    .mem_access      (mem_access),
    .data_stall      (data_stall),
    .struct_conflict (struct_conflict),
    .pc_hold         (pc_hold),
    .ifid_hold       (ifid_hold),
    .ifid_bubble     (ifid_bubble),
    .idex_bubble     (idex_bubble)
  );

  assign ex_sel_a = ex_sel[0];
  assign ex_sel_b = ex_sel[1];
  assign br_sel_a = br_sel[0];
  assign br_sel_b = br_sel[1];

endmodule

// File: rtl/fwd_stall_unit_chk.sv
module fwd_stall_unit_chk #(
  parameter int REG_AW = 5
) (
  input logic              fwd_en,
  input logic [REG_AW-1:0] ex_rs1,
  input logic [REG_AW-1:0] mem_rd,
  input logic              mem_wr,
  input logic              mem_load,
  input logic              id_branch,
  input logic [1:0]        ex_sel_a,
  input logic [1:0]        ex_sel_b,
  input logic [1:0]        br_sel_a,
  input logic [1:0]        br_sel_b,
  input logic              pc_hold,
  input logic              ifid_hold,
  input logic              ifid_bubble,
  input logic              idex_bubble,
  input logic              data_stall,
  input logic              struct_conflict
);

  // The unit has no state, so every property is a same-cycle relation.
  always_comb begin
    assert_exmem_needs_writer_R1: assert (ex_sel_a != 2'd1 || (mem_wr && mem_rd == ex_rs1))
      else $error("execute select A points at a memory stage that does not write it");
    assert_zero_never_fwd_R2: assert (ex_sel_a == 2'd0 || ex_rs1 != '0)
      else $error("register 0 forwarded");
    assert_br_no_load_fwd_R4: assert (br_sel_a != 2'd1 || !mem_load)
      else $error("branch comparator took a load result before it exists");
    assert_nofwd_all_rf_R5: assert (fwd_en || (ex_sel_a == 2'd0 && ex_sel_b == 2'd0 &&
                                               br_sel_a == 2'd0 && br_sel_b == 2'd0))
      else $error("forwarding select active with forwarding disabled");
    assert_br_sel_only_branch_R6: assert (id_branch || (br_sel_a == 2'd0 && br_sel_b == 2'd0))
      else $error("comparator select active without a branch");
    assert_freeze_holds_pc_R7: assert (!ifid_hold || (pc_hold && idex_bubble && data_stall))
      else $error("IF/ID frozen without full stall");
    assert_bubble_excl_hold_R8: assert (!(ifid_bubble && ifid_hold))
      else $error("IF/ID both held and bubbled");
    assert_bubble_from_port_R8: assert (!ifid_bubble || (struct_conflict && pc_hold))
      else $error("IF/ID bubble without a port conflict");
  end

endmodule

bind fwd_stall_unit fwd_stall_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .fwd_en          (fwd_en),
  .ex_rs1          (ex_rs1),
  .mem_rd          (mem_rd),
  .mem_wr          (mem_wr),
  .mem_load        (mem_load),
  .id_branch       (id_branch),
  .ex_sel_a        (ex_sel_a),
  .ex_sel_b        (ex_sel_b),
  .br_sel_a        (br_sel_a),
  .br_sel_b        (br_sel_b),
  .pc_hold         (pc_hold),
  .ifid_hold       (ifid_hold),
  .ifid_bubble     (ifid_bubble),
  .idex_bubble     (idex_bubble),
  .data_stall      (data_stall),
  .struct_conflict (struct_conflict)
);

// File: tb/fwd_stall_unit_tb.sv
module fwd_stall_unit_tb;

  localparam int AW = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          fwd_en, single_port, id_use1, id_use2, id_branch;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic          ex_wr, ex_load, mem_wr, mem_load, mem_access, wb_wr;
  logic [1:0]    ex_sel_a, ex_sel_b, br_sel_a, br_sel_b;
  logic          pc_hold, ifid_hold, ifid_bubble, idex_bubble;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  fwd_stall_unit #(.REG_AW(AW)) u_dut (.*);

  task automatic chk(input string tag, input string what,
                     input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    fwd_en = 1; single_port = 0; id_use1 = 0; id_use2 = 0; id_branch = 0;
    id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; mem_rd = 0; wb_rd = 0;
    ex_wr = 0; ex_load = 0; mem_wr = 0; mem_load = 0; mem_access = 0; wb_wr = 0;
  endtask

  // Inputs change at the falling edge, outputs are read 5 ns later.
  task automatic settle();
    #5;
  endtask

  task automatic chk_ctrl(input string tag, input logic pc, input logic fh,
                          input logic fb, input logic eb);
    chk(tag, "pc_hold", {1'b0, pc_hold}, {1'b0, pc});
    chk(tag, "ifid_hold", {1'b0, ifid_hold}, {1'b0, fh});
    chk(tag, "ifid_bubble", {1'b0, ifid_bubble}, {1'b0, fb});
    chk(tag, "idex_bubble", {1'b0, idex_bubble}, {1'b0, eb});
  endtask

  task automatic t_idle();
    @(negedge clk); clear_in(); settle();
    chk("R9", "ex_sel_a", ex_sel_a, 0);
    chk("R9", "ex_sel_b", ex_sel_b, 0);
    chk("R9", "br_sel_a", br_sel_a, 0);
    chk_ctrl("R9", 0, 0, 0, 0);
  endtask

  task automatic t_ex_priority();
    @(negedge clk); clear_in();
    ex_rs1 = 3; mem_rd = 3; mem_wr = 1; wb_rd = 3; wb_wr = 1; settle();
    chk("R1", "both match", ex_sel_a, 1);
    @(negedge clk); mem_wr = 0; settle();
    chk("R1", "wb only", ex_sel_a, 2);
    @(negedge clk); wb_wr = 0; settle();
    chk("R1", "no writer", ex_sel_a, 0);
    @(negedge clk); ex_rs2 = 4; wb_rd = 4; wb_wr = 1; mem_rd = 6; mem_wr = 1; settle();
    chk("R1", "operand B wb", ex_sel_b, 2);
    chk("R1", "operand A clean", ex_sel_a, 0);
  endtask

  task automatic t_zero();
    @(negedge clk); clear_in();
    mem_wr = 1; wb_wr = 1; settle();
    chk("R2", "ex_sel_a r0", ex_sel_a, 0);
    @(negedge clk); id_use1 = 1; ex_wr = 1; ex_load = 1; settle();
    chk_ctrl("R2", 0, 0, 0, 0);
    @(negedge clk); id_branch = 1; mem_load = 0; settle();
    chk("R2", "br_sel_a r0", br_sel_a, 0);
    chk_ctrl("R2", 0, 0, 0, 0);
  endtask

  task automatic t_load_use();
    @(negedge clk); clear_in();
    id_rs2 = 7; id_use2 = 1; ex_rd = 7; ex_wr = 1; ex_load = 1; settle();
    chk_ctrl("R3", 1, 1, 0, 1);
    @(negedge clk); ex_load = 0; settle();
    chk_ctrl("R3", 0, 0, 0, 0);
  endtask

  task automatic t_branch();
    @(negedge clk); clear_in();
    id_branch = 1; id_rs1 = 5; id_use1 = 1; ex_rd = 5; ex_wr = 1; settle();
    chk("R4", "alu in ex stalls", {1'b0, idex_bubble}, 1);
    @(negedge clk); ex_wr = 0; mem_rd = 5; mem_wr = 1; settle();
    chk("R4", "alu in mem sel", br_sel_a, 1);
    chk("R4", "alu in mem no stall", {1'b0, idex_bubble}, 0);
    @(negedge clk); mem_load = 1; wb_rd = 5; wb_wr = 1; settle();
    chk("R4", "load in mem sel", br_sel_a, 0);
    chk("R4", "load in mem stall", {1'b0, idex_bubble}, 1);
    @(negedge clk); mem_load = 0; mem_wr = 0; settle();
    chk("R4", "wb sel", br_sel_a, 2);
    chk("R4", "wb no stall", {1'b0, idex_bubble}, 0);
    @(negedge clk); id_rs2 = 9; id_use2 = 1; ex_rd = 9; ex_wr = 1; settle();
    chk("R4", "operand B ex stall", {1'b0, idex_bubble}, 1);
  endtask

  task automatic t_nofwd();
    @(negedge clk); clear_in(); fwd_en = 0;
    ex_rs1 = 3; mem_rd = 3; mem_wr = 1; id_rs1 = 3; id_use1 = 1; settle();
    chk("R5", "ex_sel_a off", ex_sel_a, 0);
    chk("R5", "mem match stalls", {1'b0, idex_bubble}, 1);
    @(negedge clk); mem_wr = 0; wb_rd = 3; wb_wr = 1; id_branch = 1; settle();
    chk("R5", "wb match no stall", {1'b0, idex_bubble}, 0);
    chk("R5", "br_sel_a off", br_sel_a, 0);
    @(negedge clk); id_branch = 0; ex_rd = 3; ex_wr = 1; settle();
    chk("R5", "ex alu match stalls", {1'b0, idex_bubble}, 1);
  endtask

  task automatic t_unused();
    @(negedge clk); clear_in();
    id_rs1 = 8; ex_rd = 8; ex_wr = 1; ex_load = 1; settle();
    chk("R6", "unused load-use", {1'b0, idex_bubble}, 0);
    @(negedge clk); id_branch = 1; ex_wr = 0; mem_rd = 8; mem_wr = 1; settle();
    chk("R6", "unused branch sel", br_sel_a, 0);
    @(negedge clk); id_branch = 0; id_use1 = 1; settle();
    chk("R6", "non-branch sel", br_sel_a, 0);
  endtask

  task automatic t_struct();
    @(negedge clk); clear_in(); single_port = 1; mem_access = 1; settle();
    chk_ctrl("R8", 1, 0, 1, 0);
    @(negedge clk); single_port = 0; settle();
    chk_ctrl("R9", 0, 0, 0, 0);
    // Port conflict and load-use stall together.
    @(negedge clk); single_port = 1; id_rs1 = 2; id_use1 = 1;
    ex_rd = 2; ex_wr = 1; ex_load = 1; settle();
    chk_ctrl("R8", 1, 1, 0, 1);
    chk_ctrl("R7", 1, 1, 0, 1);
    // Port conflict from the very load a branch is waiting on.
    @(negedge clk); ex_wr = 0; id_branch = 1; mem_rd = 2; mem_wr = 1; mem_load = 1; settle();
    chk_ctrl("R8", 1, 1, 0, 1);
  endtask

  // Independent model for the random sweep.
  task automatic ref_check(input int it);
    logic [1:0] e_ex [2];
    logic [1:0] e_br [2];
    logic       st;
    logic [AW-1:0] es [2];
    logic [AW-1:0] is [2];
    logic          us [2];
    es[0] = ex_rs1; es[1] = ex_rs2; is[0] = id_rs1; is[1] = id_rs2;
    us[0] = id_use1; us[1] = id_use2;
    st = 0;
    for (int k = 0; k < 2; k++) begin
      logic m, w, x;
      e_ex[k] = 0;
      if (fwd_en && es[k] != 0) begin
        if (mem_wr && mem_rd == es[k]) e_ex[k] = 1;
        else if (wb_wr && wb_rd == es[k]) e_ex[k] = 2;
      end
      x = us[k] && is[k] != 0 && ex_wr && ex_rd == is[k];
      m = us[k] && is[k] != 0 && mem_wr && mem_rd == is[k];
      w = us[k] && is[k] != 0 && wb_wr && wb_rd == is[k];
      e_br[k] = 0;
      case ({fwd_en, id_branch})
        2'b00, 2'b01: st |= x | m;
        2'b10:        st |= x & ex_load;
        default: begin
          st |= x | (m & mem_load);
          e_br[k] = m ? (mem_load ? 2'd0 : 2'd1) : (w ? 2'd2 : 2'd0);
        end
      endcase
    end
    chk("R1", $sformatf("rand %0d ex_sel_a", it), ex_sel_a, e_ex[0]);
    chk("R1", $sformatf("rand %0d ex_sel_b", it), ex_sel_b, e_ex[1]);
    chk("R4", $sformatf("rand %0d br_sel_a", it), br_sel_a, e_br[0]);
    chk("R4", $sformatf("rand %0d br_sel_b", it), br_sel_b, e_br[1]);
    chk_ctrl("R7", st | (single_port & mem_access), st, (single_port & mem_access) & ~st, st);
  endtask

  task automatic t_random();
    for (int it = 0; it < 600; it++) begin
      @(negedge clk);
      fwd_en = ($urandom_range(0, 3) != 0); single_port = $urandom_range(0, 1);
      id_use1 = $urandom_range(0, 1); id_use2 = $urandom_range(0, 1);
      id_branch = $urandom_range(0, 1);
      id_rs1 = AW'($urandom_range(0, 3)); id_rs2 = AW'($urandom_range(0, 3));
      ex_rs1 = AW'($urandom_range(0, 3)); ex_rs2 = AW'($urandom_range(0, 3));
      ex_rd = AW'($urandom_range(0, 3)); mem_rd = AW'($urandom_range(0, 3));
      wb_rd = AW'($urandom_range(0, 3));
      ex_wr = $urandom_range(0, 1); ex_load = $urandom_range(0, 1);
      mem_wr = $urandom_range(0, 1); mem_load = $urandom_range(0, 1);
      mem_access = $urandom_range(0, 1); wb_wr = $urandom_range(0, 1);
      settle();
      ref_check(it);
    end
  endtask

  initial begin
    clear_in();
    t_idle();
    t_ex_priority();
    t_zero();
    t_load_use();
    t_branch();
    t_nofwd();
    t_unused();
    t_struct();
    t_random();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule